// File: doc/BRIEF.md
# Page-Buffered Self-Timed Write Controller

This block sits behind a two-wire serial bus engine in a small non-volatile byte store. After the bus engine has decoded a write command and its word address, it hands the block a load strobe with that address, then one strobe for each data byte it receives. The block collects these bytes in a page latch of eight entries. The latch slot comes from the low three address bits, and only those bits advance after each byte. The upper address bits pick the page and stay fixed for the whole transaction. When more than eight bytes arrive, the offset wraps and a newer byte replaces the older byte at the same slot.

The memory array is not touched until the bus engine reports the closing STOP. If at least one byte was latched, the block then starts a self-timed write cycle. During that cycle it raises a busy flag, which the bus engine uses to withhold acknowledges. While busy is high the block ignores every input strobe and blocks reads. Only the latch slots that were actually filled are written, so the other locations of the page keep their contents. A transaction that ends with no data bytes, including one cut short by a new address load, starts no cycle and leaves the array untouched. The array is modelled as registers and holds 128 or 256 bytes, chosen by a parameter. In the 128-byte version, the address MSB is ignored.

Top module: `page_commit_ctrl`

## Requirements
- R1: After reset, busy_o is 0, rd_ready_o is 1, arr_we_o is 0 and every array location reads 0.
- R2: Data byte k of a transaction (counting from 0) is written to the array address whose upper bits (bits 7..3) equal those of the loaded word address and whose low three bits are (loaded bits 2..0 + k) mod 8.
- R3: When more than eight bytes arrive before STOP, each slot receives the last byte that mapped to it.
- R4: No array location changes, and arr_we_o stays 0, before the STOP of a transaction.
- R5: A STOP strobe with at least one latched byte raises busy_o on the next clock edge, and busy_o then stays high for exactly WRITE_CYCLES cycles.
- R6: Array locations of the page whose slots received no byte in the transaction keep their previous values.
- R7: A STOP with no latched bytes, including one after a new address load that discarded earlier bytes, leaves busy_o low and the array unchanged.
- R8: While busy_o is high, address loads, data bytes and STOP strobes are ignored. They latch nothing and start no later write cycle.
- R9: While busy_o is high, rd_ready_o is 0 and rd_data_o is 0. Otherwise rd_data_o shows the array byte at rd_addr_i.
- R10: With DEPTH = 128, bit 7 of both the write and the read address is ignored, so addresses 0x85 and 0x05 name the same location.
- R11: arr_we_o is only ever high while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load_i | input | 1 | Starts a write transaction at addr_i and clears the latch |
| addr_i | input | 8 | Word address of the transaction |
| byte_vld_i | input | 1 | One received data byte is on byte_i |
| byte_i | input | 8 | Data byte |
| stop_i | input | 1 | Transaction ended with STOP; commits if any byte was latched |
| rd_addr_i | input | 8 | Read address |
| busy_o | output | 1 | Self-timed write cycle in progress |
| rd_ready_o | output | 1 | Read data valid (low while busy) |
| rd_data_o | output | 8 | Array byte at rd_addr_i, zero while busy |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | log2(DEPTH) | Array write address |
| arr_wdata_o | output | 8 | Array write data |

## Verification
On every cycle the assertions check the following: array writes stay inside the page of the last accepted address load and only happen while busy; busy lasts exactly WRITE_CYCLES cycles; a STOP after latched bytes raises busy, while a STOP without bytes does not; reads are blocked during busy. Other behaviour shows only in the contents of the array, so only the bench scenarios can show it. This covers offset wrap and overwrite order, untouched neighbours in a partly written page, discarded bytes after a restart, strobes ignored during busy, and address aliasing in the 128-byte variant.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
   typedef enum logic [0:0] {
      WR_IDLE  = 1'b0,
      WR_TIMED = 1'b1
   } wr_state_e;

   function automatic bit depth_ok(input int unsigned d);
      return (d == 128) || (d == 256);
   endfunction
endpackage

// File: rtl/pcc_page_latch.sv
module pcc_page_latch #(
   parameter int unsigned PAGE_BYTES = 8,
   parameter int unsigned DATA_W     = 8,
   localparam int unsigned OFF_W     = $clog2(PAGE_BYTES)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         load_i,
   input  logic [OFF_W-1:0]             off_i,
   input  logic                         wr_i,
   input  logic [DATA_W-1:0]            data_i,
   input  logic                         clear_i,
   output logic [PAGE_BYTES-1:0]        mask_o,
   output logic [PAGE_BYTES*DATA_W-1:0] entries_o
);
   logic [OFF_W-1:0] off_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q <= '0;
      end else if (load_i) begin
         off_q <= off_i;
      end else if (wr_i) begin
         off_q <= off_q + 1'b1;
      end
   end

   for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
      logic [DATA_W-1:0] data_q;
      logic              vld_q;
      logic              hit;

      assign hit = wr_i && !load_i && (off_q == OFF_W'(s));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            data_q <= '0;
            vld_q  <= 1'b0;
         end else begin
            if (load_i || clear_i) begin
               vld_q <= 1'b0;
            end else if (hit) begin
               vld_q <= 1'b1;
            end
            if (hit) begin
               data_q <= data_i;
            end
         end
      end

      assign mask_o[s]                       = vld_q;
      assign entries_o[s*DATA_W +: DATA_W]   = data_q;
   end
endmodule

// File: rtl/pcc_write_timer.sv
module pcc_write_timer
   import pcc_pkg::*;
#(
   parameter int unsigned WRITE_CYCLES = 100000,
   parameter int unsigned PAGE_BYTES   = 8,
   localparam int unsigned OFF_W       = $clog2(PAGE_BYTES),
   localparam int unsigned CNT_W       = $clog2(WRITE_CYCLES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             slot_vld_o,
   output logic [OFF_W-1:0] slot_o
);
   localparam logic [CNT_W-1:0] LAST_C = CNT_W'(WRITE_CYCLES - 1);
   localparam logic [CNT_W-1:0] PAGE_C = CNT_W'(PAGE_BYTES);

   wr_state_e        state_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WR_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            WR_IDLE: begin
               cnt_q <= '0;
               if (go_i) begin
                  state_q <= WR_TIMED;
               end
            end
            WR_TIMED: begin
               if (cnt_q == LAST_C) begin
                  state_q <= WR_IDLE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= WR_IDLE;
         endcase
      end
   end

   assign busy_o     = (state_q == WR_TIMED);
   assign done_o     = busy_o && (cnt_q == LAST_C);
   assign slot_vld_o = busy_o && (cnt_q < PAGE_C);
   assign slot_o     = cnt_q[OFF_W-1:0];
endmodule

// File: rtl/pcc_array.sv
module pcc_array #(
   parameter int unsigned DEPTH  = 256,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [AW-1:0]     waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [AW-1:0]     raddr_i,
   output logic [DATA_W-1:0] rdata_o
);
   logic [DATA_W-1:0] rd_vec [DEPTH];

   for (genvar a = 0; a < DEPTH; a++) begin : g_cell
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (we_i && (waddr_i == AW'(a))) begin
            q <= wdata_i;
         end
      end
      assign rd_vec[a] = q;
   end

   assign rdata_o = rd_vec[raddr_i];
endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl
   import pcc_pkg::*;
#(
   parameter int unsigned DEPTH        = 256,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned PAGE_BYTES   = 8,
   parameter int unsigned ADDR_IN_W    = 8,
   parameter int unsigned WRITE_CYCLES = 100000,
   localparam int unsigned AW          = $clog2(DEPTH),
   localparam int unsigned OFF_W       = $clog2(PAGE_BYTES),
   localparam int unsigned PG_W        = AW - OFF_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 addr_load_i,
   input  logic [ADDR_IN_W-1:0] addr_i,
   input  logic                 byte_vld_i,
   input  logic [DATA_W-1:0]    byte_i,
   input  logic                 stop_i,
   input  logic [ADDR_IN_W-1:0] rd_addr_i,
   output logic                 busy_o,
   output logic                 rd_ready_o,
   output logic [DATA_W-1:0]    rd_data_o,
   output logic                 arr_we_o,
   output logic [AW-1:0]        arr_addr_o,
   output logic [DATA_W-1:0]    arr_wdata_o
);
   // elaboration-time parameter checks
   if (!depth_ok(DEPTH)) begin : g_bad_depth
      $error("page_commit_ctrl: DEPTH must be 128 or 256");
   end
   if ((1 << OFF_W) != PAGE_BYTES) begin : g_bad_page
      $error("page_commit_ctrl: PAGE_BYTES must be a power of two");
   end
   if (WRITE_CYCLES < PAGE_BYTES) begin : g_bad_cycles
      $error("page_commit_ctrl: WRITE_CYCLES must cover one slot per cycle");
   end
   if (AW > ADDR_IN_W) begin : g_bad_addr
      $error("page_commit_ctrl: address input narrower than array");
   end

   logic [AW-1:0] waddr_eff;
   logic [AW-1:0] raddr_eff;

   // narrow array: upper address bits are dropped
   if (AW < ADDR_IN_W) begin : g_trim
      logic [ADDR_IN_W-AW-1:0] unused_hi;
      assign waddr_eff = addr_i[AW-1:0];
      assign raddr_eff = rd_addr_i[AW-1:0];
      assign unused_hi = addr_i[ADDR_IN_W-1:AW] ^ rd_addr_i[ADDR_IN_W-1:AW];
   end else begin : g_full
      assign waddr_eff = addr_i;
      assign raddr_eff = rd_addr_i;
   end

   logic                         accept;
   logic                         any_byte;
   logic                         go;
   logic                         done;
   logic                         slot_vld;
   logic [OFF_W-1:0]             slot;
   logic [PAGE_BYTES-1:0]        mask;
   logic [PAGE_BYTES*DATA_W-1:0] entries;
   logic [PG_W-1:0]              page_q;
   logic [DATA_W-1:0]            arr_rdata;

   assign accept   = !busy_o;
   assign any_byte = |mask;
   assign go       = accept && stop_i && any_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= '0;
      end else if (accept && addr_load_i) begin
         page_q <= waddr_eff[AW-1:OFF_W];
      end
   end

   pcc_page_latch #(
      .PAGE_BYTES (PAGE_BYTES),
      .DATA_W     (DATA_W)
   ) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (accept && addr_load_i),
      .off_i     (waddr_eff[OFF_W-1:0]),
      .wr_i      (accept && byte_vld_i),
      .data_i    (byte_i),
      .clear_i   (done || (accept && stop_i && !any_byte)),
      .mask_o    (mask),
      .entries_o (entries)
   );

   pcc_write_timer #(
      .WRITE_CYCLES (WRITE_CYCLES),
      .PAGE_BYTES   (PAGE_BYTES)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .go_i       (go),
      .busy_o     (busy_o),
      .done_o     (done),
      .slot_vld_o (slot_vld),
      .slot_o     (slot)
   );

   assign arr_we_o    = slot_vld && mask[slot];
   assign arr_addr_o  = {page_q, slot};
   assign arr_wdata_o = entries[slot*DATA_W +: DATA_W];

   pcc_array #(
      .DEPTH  (DEPTH),
      .DATA_W (DATA_W)
   ) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (arr_we_o),
      .waddr_i (arr_addr_o),
      .wdata_i (arr_wdata_o),
      .raddr_i (raddr_eff),
      .rdata_o (arr_rdata)
   );

   assign rd_ready_o = accept;
   assign rd_data_o  = busy_o ? '0 : arr_rdata;
endmodule

// File: rtl/pcc_checker.sv
module pcc_checker #(
   parameter int unsigned DEPTH        = 256,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned PAGE_BYTES   = 8,
   parameter int unsigned ADDR_IN_W    = 8,
   parameter int unsigned WRITE_CYCLES = 100000,
   localparam int unsigned AW          = $clog2(DEPTH),
   localparam int unsigned OFF_W       = $clog2(PAGE_BYTES),
   localparam int unsigned CNT_W       = $clog2(WRITE_CYCLES + 1)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 addr_load_i,
   input logic [ADDR_IN_W-1:0] addr_i,
   input logic                 byte_vld_i,
   input logic                 stop_i,
   input logic                 busy_o,
   input logic                 rd_ready_o,
   input logic [DATA_W-1:0]    rd_data_o,
   input logic                 arr_we_o,
   input logic [AW-1:0]        arr_addr_o
);
   localparam logic [CNT_W-1:0] WC_C = CNT_W'(WRITE_CYCLES);

   logic [AW-OFF_W-1:0] ref_page_q;
   logic                had_byte_q;
   logic [CNT_W-1:0]    busy_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_page_q <= '0;
         had_byte_q <= 1'b0;
         busy_cnt_q <= '0;
      end else begin
         if (!busy_o && addr_load_i) begin
            ref_page_q <= addr_i[AW-1:OFF_W];
         end
         if (!busy_o && (addr_load_i || stop_i)) begin
            had_byte_q <= 1'b0;
         end else if (!busy_o && byte_vld_i) begin
            had_byte_q <= 1'b1;
         end
         busy_cnt_q <= busy_o ? busy_cnt_q + 1'b1 : '0;
      end
   end

   AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we_o |-> busy_o);                                                     // R11
   AST_WE_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we_o |-> (arr_addr_o[AW-1:OFF_W] == ref_page_q));                     // R2
   AST_READ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (!rd_ready_o && (rd_data_o == '0)));                           // R9
   AST_COMMIT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !busy_o && !addr_load_i && had_byte_q) |=> busy_o);            // R5
   AST_EMPTY_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !busy_o && !had_byte_q && !byte_vld_i) |=> !busy_o);           // R7
   AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (busy_cnt_q < WC_C));                                          // R5
   AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (busy_cnt_q == WC_C));                                  // R5
endmodule

bind page_commit_ctrl pcc_checker #(
   .DEPTH        (DEPTH),
   .DATA_W       (DATA_W),
   .PAGE_BYTES   (PAGE_BYTES),
   .ADDR_IN_W    (ADDR_IN_W),
   .WRITE_CYCLES (WRITE_CYCLES)
) i_pcc_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .addr_load_i (addr_load_i),
   .addr_i      (addr_i),
   .byte_vld_i  (byte_vld_i),
   .stop_i      (stop_i),
   .busy_o      (busy_o),
   .rd_ready_o  (rd_ready_o),
   .rd_data_o   (rd_data_o),
   .arr_we_o    (arr_we_o),
   .arr_addr_o  (arr_addr_o)
);

// File: tb/test_page_commit_ctrl.sv
`timescale 1ns/1ps
module test_page_commit_ctrl;
   localparam int WC = 24;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       addr_load = 1'b0;
   logic [7:0] addr = '0;
   logic       byte_vld = 1'b0;
   logic [7:0] byte_d = '0;
   logic       stop = 1'b0;
   logic [7:0] rd_addr = '0;

   logic       busy, rd_ready, we;
   logic [7:0] rd_data, waddr, wdata;
   logic       busy_s, rd_ready_s, we_s;
   logic [7:0] rd_data_s, wdata_s;
   logic [6:0] waddr_s;

   int checks = 0;
   int fails  = 0;
   logic [7:0] model [256];

   always #10 clk = ~clk;

   page_commit_ctrl #(.DEPTH(256), .WRITE_CYCLES(WC)) i_page_commit_ctrl (
      .clk(clk), .rst_n(rst_n), .addr_load_i(addr_load), .addr_i(addr),
      .byte_vld_i(byte_vld), .byte_i(byte_d), .stop_i(stop), .rd_addr_i(rd_addr),
      .busy_o(busy), .rd_ready_o(rd_ready), .rd_data_o(rd_data),
      .arr_we_o(we), .arr_addr_o(waddr), .arr_wdata_o(wdata));

   page_commit_ctrl #(.DEPTH(128), .WRITE_CYCLES(WC)) i_page_commit_ctrl_small (
      .clk(clk), .rst_n(rst_n), .addr_load_i(addr_load), .addr_i(addr),
      .byte_vld_i(byte_vld), .byte_i(byte_d), .stop_i(stop), .rd_addr_i(rd_addr),
      .busy_o(busy_s), .rd_ready_o(rd_ready_s), .rd_data_o(rd_data_s),
      .arr_we_o(we_s), .arr_addr_o(waddr_s), .arr_wdata_o(wdata_s));

   // stimulus vectors: {word address, byte count, first data value}
   localparam int NV = 6;
   localparam logic [20:0] VEC [NV] = '{
      {8'h10, 5'd1,  8'hA1},
      {8'h23, 5'd8,  8'h30},
      {8'h46, 5'd11, 8'h50},
      {8'h78, 5'd3,  8'h70},
      {8'hFE, 5'd4,  8'h90},
      {8'h10, 5'd2,  8'hC0}
   };

   task automatic check(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse_load(input logic [7:0] a);
      @(negedge clk); addr_load = 1'b1; addr = a;
      @(negedge clk); addr_load = 1'b0;
   endtask

   task automatic pulse_byte(input logic [7:0] d);
      @(negedge clk); byte_vld = 1'b1; byte_d = d;
      @(negedge clk); byte_vld = 1'b0;
   endtask

   task automatic pulse_stop();
      @(negedge clk); stop = 1'b1;
      @(negedge clk); stop = 1'b0;
   endtask

   task automatic read_at(input logic [7:0] a, output logic [7:0] d);
      rd_addr = a; #1; d = rd_data;
   endtask

   // counts busy cycles from the current negedge; checks read blocking on the first
   task automatic wait_busy(output int n);
      n = 0;
      while (busy && n < 1000) begin
         if (n == 0) begin
            rd_addr = 8'h00; #1;
            check(!rd_ready && rd_data == 8'h00, "R9 read blocked while busy",
                  {rd_ready, rd_data}, 0);
         end
         n++;
         @(negedge clk);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      logic [7:0] d;
      int n;
      for (int i = 0; i < 256; i++) model[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(!busy && rd_ready && !we, "R1 reset flags", {busy, rd_ready, we}, 3'b010);
      for (int a = 0; a < 256; a += 37) begin
         read_at(8'(a), d);
         check(d == 8'h00, "R1 array cleared", d, 0);
      end

      // vector table: page writes
      for (int v = 0; v < NV; v++) begin
         logic [7:0] a0, b0;
         int cnt;
         a0 = VEC[v][20:13]; cnt = int'(VEC[v][12:8]); b0 = VEC[v][7:0];
         pulse_load(a0);
         for (int k = 0; k < cnt; k++) pulse_byte(b0 + 8'(k));
         // R4: nothing committed before STOP
         read_at(a0, d);
         check(d == model[a0] && !we, "R4 no write before stop", d, model[a0]);
         pulse_stop();
         check(busy == 1'b1, "R5 busy after stop", busy, 1);
         wait_busy(n);
         check(n == WC, "R5 busy length", n, WC);
         for (int k = 0; k < cnt; k++)
            model[{a0[7:3], 3'(a0[2:0] + 3'(k))}] = b0 + 8'(k);
         for (int s = 0; s < 8; s++) begin
            logic [7:0] pa;
            pa = {a0[7:3], 3'(s)};
            read_at(pa, d);
            // R2 placement, R3 overwrite order, R6 untouched slots
            check(d == model[pa], (cnt > 8) ? "R3 wrapped overwrite" :
                  (s < cnt) ? "R2 page placement" : "R6 untouched slot", d, model[pa]);
         end
         read_at({a0[7:3] + 5'd1, 3'd0}, d);
         check(d == model[{a0[7:3] + 5'd1, 3'd0}], "R2 next page untouched",
               d, model[{a0[7:3] + 5'd1, 3'd0}]);
      end

      // R7: restart discards bytes, empty stop starts nothing
      pulse_load(8'h30);
      pulse_byte(8'hEE);
      pulse_byte(8'hEF);
      pulse_load(8'h30);
      pulse_stop();
      check(!busy, "R7 empty stop no cycle", busy, 0);
      repeat (3) @(negedge clk);
      check(!busy, "R7 still idle", busy, 0);
      read_at(8'h30, d);
      check(d == model[8'h30], "R7 array unchanged", d, model[8'h30]);
      read_at(8'h31, d);
      check(d == model[8'h31], "R7 array unchanged 2", d, model[8'h31]);

      // R8: strobes ignored during busy
      pulse_load(8'h60);
      pulse_byte(8'h11);
      pulse_stop();
      model[8'h60] = 8'h11;
      pulse_load(8'h61);
      pulse_byte(8'h22);
      pulse_byte(8'h33);
      pulse_stop();
      check(busy, "R8 still in first cycle", busy, 1);
      wait_busy(n);
      read_at(8'h60, d);
      check(d == 8'h11, "R8 committed byte kept", d, 8'h11);
      read_at(8'h61, d);
      check(d == model[8'h61], "R8 ignored byte absent", d, model[8'h61]);
      pulse_stop();
      check(!busy, "R8 nothing latched during busy", busy, 0);

      // R10: narrow variant ignores address MSB
      pulse_load(8'h85);
      pulse_byte(8'h5A);
      pulse_stop();
      model[8'h85] = 8'h5A;
      check(busy_s, "R10 narrow busy", busy_s, 1);
      wait_busy(n);
      rd_addr = 8'h05; #1;
      check(rd_data_s == 8'h5A, "R10 alias low", rd_data_s, 8'h5A);
      rd_addr = 8'h85; #1;
      check(rd_data_s == 8'h5A, "R10 alias high", rd_data_s, 8'h5A);
      read_at(8'h05, d);
      check(d == model[8'h05], "R10 wide array distinct", d, model[8'h05]);

      // R11: no write strobe while idle
      @(negedge clk);
      check(!we && !busy, "R11 idle no write", we, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule